// File: doc/BRIEF.md
# ATA Device Interrupt Request Controller

This block produces the interrupt request line of an ATA device from host register traffic and from completion events raised by the device's command engine. It holds an interrupt-pending flag that is separate from the line itself. The host can mask the line with the interrupt-disable bit of the device control register, or by selecting the other device. Later it can unmask the line again and recover the interrupt that was still waiting. Reading the primary status register or issuing a new command acknowledges the interrupt. Reading the alternate status copy leaves it in place.

The command engine pulses one input per completion kind: no-data command done, DMA done, a PIO block ready (with a flag saying whether it should interrupt), diagnostics started, and diagnostics done (with a flag saying whether an interrupt is wanted). Each event sets the pending flag according to its own rule and drives the line when interrupts are enabled. Register read data, command decoding and every other status bit live outside this block.

Top module: `ata_irq_pending`

## Requirements
- R1: After reset the line is low, nothing is pending, device 0 is selected and interrupts are enabled.
- R2: A read strobe at address 0 (primary status) clears the pending flag, and the line is low after the next edge.
- R3: A read strobe at address 1 (alternate status) changes neither the line nor the pending flag.
- R4: A write strobe at address 4 (command) clears the pending flag, and the line is low after the next edge.
- R5: A write at address 3 (device control) with data bit 1 set disables interrupts and drops the line. The pending flag is kept.
- R6: A write at address 3 with data bit 1 clear enables interrupts. If interrupts had been disabled, device 0 is selected and an interrupt is pending, the line rises after the next edge.
- R7: A write at address 2 (device select) whose data bit 4 moves the selection from device 0 to 1 drops the line. The pending flag is kept.
- R8: A write at address 2 that moves the selection from device 1 to 0 raises the line when interrupts are enabled and an interrupt is pending.
- R9: A no-data completion or a DMA completion sets the pending flag. It raises the line only when interrupts are enabled.
- R10: A PIO-ready event with its want-interrupt flag set, while interrupts are enabled, sets the pending flag and raises the line. In every other case it leaves both unchanged.
- R11: Diagnostics start clears the pending flag and the line. Diagnostics done with its want flag behaves as R9. Without the want flag it changes nothing.
- R12: When a completion event and a clearing register access land in the same cycle, the event wins: the flag is set and the line follows the enable.
- R13: The line is a registered level. It changes only on the edge after a causing strobe or event, it is never high without a pending interrupt, and otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_rd | input | 1 | Host register read strobe, one cycle |
| reg_wr | input | 1 | Host register write strobe, one cycle |
| reg_addr | input | 3 | Register code: 0 status, 1 alternate status, 2 device select, 3 device control, 4 command |
| reg_wdata | input | DATA_W | Write data |
| done_nodata | input | 1 | No-data command completed |
| done_dma | input | 1 | DMA transfer completed |
| pio_ready | input | 1 | PIO block ready for the host |
| pio_want_irq | input | 1 | PIO-ready event asks for an interrupt |
| diag_start | input | 1 | Device diagnostics started |
| diag_done | input | 1 | Device diagnostics finished |
| diag_want_irq | input | 1 | Diagnostics finish asks for an interrupt (low when part of a reset) |
| intrq | output | 1 | Interrupt request line, active high |

## Verification
The bench starts from every combination of enable, selected device and pending flag and applies every kind of strobe and event. After each one it reads the pending flag back through the ports by selecting device 0, masking and then unmasking. A design that cleared the flag on masking or on a device 1 selection would lose the interrupt on restore. One that acknowledged on the alternate status read would lose it too. One that ignored the previous enable state on unmask would raise a spurious line. The same-cycle cases, an acknowledge together with a completion, check that a design giving priority to the clear would drop a fresh interrupt.

// File: rtl/ata_irq_pkg.sv
// Shared types for the ATA interrupt request controller.
// Assumes a 3-bit register code on the host side.
package ata_irq_pkg;

    localparam int unsigned REG_CODE_W = 3;

    typedef enum logic [REG_CODE_W-1:0] {
        REG_STATUS  = 3'd0,
        REG_ALTSTAT = 3'd1,
        REG_DEVSEL  = 3'd2,
        REG_DEVCTL  = 3'd3,
        REG_COMMAND = 3'd4
    } reg_code_e;

    // Host actions decoded from one strobe cycle.
    typedef struct packed {
        logic ack;       // acknowledge: status read or command write
        logic ctl_wr;    // device control written
        logic ctl_mask;  // interrupt-disable bit value written
        logic sel_wr;    // device select written
        logic sel_dev;   // device number written
    } host_act_t;

    // Engine events reduced to their effect class.
    typedef struct packed {
        logic clr;       // diagnostics start: drop pending and line
        logic set_any;   // set pending regardless of enable
        logic set_en;    // set pending only when enabled
    } eng_evt_t;

endpackage

// File: rtl/ata_irq_decode.sv
// Host strobe decoder: turns a read or write strobe and its register code
// into the actions the interrupt state cares about.
// Assumes at most one register code per cycle and one-cycle strobes.
module ata_irq_decode
    import ata_irq_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NIEN_BIT = 1,
    parameter int unsigned DEV_BIT  = 4
) (
    input  logic                  rd,
    input  logic                  wr,
    input  logic [REG_CODE_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output host_act_t             act
);

    // Decode strobe and code into host actions.
    always_comb begin
        act          = '0;
        act.ack      = (rd && addr == REG_STATUS) || (wr && addr == REG_COMMAND);
        act.ctl_wr   = wr && addr == REG_DEVCTL;
        act.ctl_mask = wdata[NIEN_BIT];
        act.sel_wr   = wr && addr == REG_DEVSEL;
        act.sel_dev  = wdata[DEV_BIT];
    end

endmodule

// File: rtl/ata_irq_events.sv
// Engine event classifier: groups completion pulses by how they affect
// the pending flag. Assumes each event input is a one-cycle pulse.
module ata_irq_events
    import ata_irq_pkg::*;
(
    input  logic     done_nodata,
    input  logic     done_dma,
    input  logic     pio_ready,
    input  logic     pio_want_irq,
    input  logic     diag_start,
    input  logic     diag_done,
    input  logic     diag_want_irq,
    output eng_evt_t evt
);

    // Classify events; reset-time diagnostics with no want flag record nothing.
    always_comb begin
        evt.clr     = diag_start;
        evt.set_any = done_nodata || done_dma || (diag_done && diag_want_irq);
        evt.set_en  = pio_ready && pio_want_irq;
    end

endmodule

// File: rtl/ata_irq_state.sv
// Interrupt state: pending flag, enable, selected device and the registered
// request line. Host actions are applied first; engine events then override,
// so an event in the same cycle as an acknowledge is never lost.
module ata_irq_state
    import ata_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  host_act_t act,
    input  eng_evt_t  evt,
    output logic      pend_q,
    output logic      en_q,
    output logic      dev_q,
    output logic      intrq_q
);

    logic pend_d, en_d, dev_d, intrq_d;

    // Next-state rules: acknowledge, mask/unmask, device select, then events.
    always_comb begin
        pend_d  = pend_q;
        en_d    = en_q;
        dev_d   = dev_q;
        intrq_d = intrq_q;

        if (act.ack || evt.clr) begin
            pend_d  = 1'b0;
            intrq_d = 1'b0;
        end

        if (act.ctl_wr) begin
            if (act.ctl_mask) begin
                intrq_d = 1'b0;
                en_d    = 1'b0;
            end else begin
                if (!en_q && !dev_q && pend_d) begin
                    intrq_d = 1'b1;
                end
                en_d = 1'b1;
            end
        end

        if (act.sel_wr) begin
            if (!dev_q && act.sel_dev) begin
                intrq_d = 1'b0;
            end else if (dev_q && !act.sel_dev && en_d && pend_d) begin
                intrq_d = 1'b1;
            end
            dev_d = act.sel_dev;
        end

        if (evt.set_any) begin
            pend_d = 1'b1;
            if (en_d) begin
                intrq_d = 1'b1;
            end
        end

        if (evt.set_en && en_d) begin
            pend_d  = 1'b1;
            intrq_d = 1'b1;
        end
    end

    // State registers with synchronous reset to enabled, device 0, idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            en_q    <= 1'b1;
            dev_q   <= 1'b0;
            intrq_q <= 1'b0;
        end else begin
            pend_q  <= pend_d;
            en_q    <= en_d;
            dev_q   <= dev_d;
            intrq_q <= intrq_d;
        end
    end

endmodule

// File: rtl/ata_irq_pending.sv
// Top of the ATA interrupt request controller. Wires the host decoder and
// the event classifier into the state block; the line is a register output.
// Assumes one-cycle strobes and pulses, synchronous to clk.
module ata_irq_pending
    import ata_irq_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NIEN_BIT = 1,
    parameter int unsigned DEV_BIT  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_rd,
    input  logic                  reg_wr,
    input  logic [REG_CODE_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic                  done_nodata,
    input  logic                  done_dma,
    input  logic                  pio_ready,
    input  logic                  pio_want_irq,
    input  logic                  diag_start,
    input  logic                  diag_done,
    input  logic                  diag_want_irq,
    output logic                  intrq
);

    host_act_t host_act;
    eng_evt_t  eng_evt;
    logic      pend_q, en_q, dev_q, intrq_q;

    ata_irq_decode #(
        .DATA_W  (DATA_W),
        .NIEN_BIT(NIEN_BIT),
        .DEV_BIT (DEV_BIT)
    ) u_decode (
        .rd   (reg_rd),
        .wr   (reg_wr),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .act  (host_act)
    );

    ata_irq_events u_events (
        .done_nodata  (done_nodata),
        .done_dma     (done_dma),
        .pio_ready    (pio_ready),
        .pio_want_irq (pio_want_irq),
        .diag_start   (diag_start),
        .diag_done    (diag_done),
        .diag_want_irq(diag_want_irq),
        .evt          (eng_evt)
    );

    ata_irq_state u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (host_act),
        .evt    (eng_evt),
        .pend_q (pend_q),
        .en_q   (en_q),
        .dev_q  (dev_q),
        .intrq_q(intrq_q)
    );

    assign intrq = intrq_q;

endmodule

// File: rtl/ata_irq_checker.sv
// Property checker for the ATA interrupt request controller, bound to the top.
// Observes ports plus the pending, enable and device registers.
module ata_irq_checker
    import ata_irq_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NIEN_BIT = 1,
    parameter int unsigned DEV_BIT  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_rd,
    input logic                  reg_wr,
    input logic [REG_CODE_W-1:0] reg_addr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic                  done_nodata,
    input logic                  done_dma,
    input logic                  pio_ready,
    input logic                  pio_want_irq,
    input logic                  diag_start,
    input logic                  diag_done,
    input logic                  diag_want_irq,
    input logic                  intrq,
    input logic                  pend_q,
    input logic                  en_q,
    input logic                  dev_q
);

    logic any_set, any_evt;
    assign any_set = done_nodata || done_dma || (pio_ready && pio_want_irq)
                     || (diag_done && diag_want_irq);
    assign any_evt = any_set || diag_start;

    p_status_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == REG_STATUS && !any_set) |=> (!intrq && !pend_q));

    p_altstat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == REG_ALTSTAT && !reg_wr && !any_evt)
        |=> ($stable(intrq) && $stable(pend_q)));

    p_command_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_COMMAND && !any_set) |=> (!intrq && !pend_q));

    p_mask_keeps_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_DEVCTL && reg_wdata[NIEN_BIT] && !reg_rd && !any_evt)
        |=> (!intrq && !en_q && pend_q == $past(pend_q)));

    p_select_dev1_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_DEVSEL && !dev_q && reg_wdata[DEV_BIT] && !any_set)
        |=> !intrq);

    p_select_dev0_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_DEVSEL && dev_q && !reg_wdata[DEV_BIT]
         && en_q && pend_q && !reg_rd && !diag_start)
        |=> intrq);

    p_completion_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_nodata || done_dma) && en_q
         && !(reg_wr && reg_addr == REG_DEVCTL && reg_wdata[NIEN_BIT]))
        |=> (intrq && pend_q));

    p_pio_no_want_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pio_ready && !pio_want_irq && !any_set && !pend_q) |=> !pend_q);

    p_line_needs_pend_r13: assert property (@(posedge clk) disable iff (!rst_n)
        intrq |-> pend_q);

endmodule

bind ata_irq_pending ata_irq_checker #(
    .DATA_W  (DATA_W),
    .NIEN_BIT(NIEN_BIT),
    .DEV_BIT (DEV_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_rd       (reg_rd),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .done_nodata  (done_nodata),
    .done_dma     (done_dma),
    .pio_ready    (pio_ready),
    .pio_want_irq (pio_want_irq),
    .diag_start   (diag_start),
    .diag_done    (diag_done),
    .diag_want_irq(diag_want_irq),
    .intrq        (intrq),
    .pend_q       (pend_q),
    .en_q         (en_q),
    .dev_q        (dev_q)
);

// File: tb/sim_ata_irq_pending.sv
`timescale 1ns/1ps
// Bench: sweeps every start state (enable, device, pending) against every
// operation, predicting the line from the requirements and reading the
// pending flag back through a select/mask/unmask probe.
module sim_ata_irq_pending;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic       done_nodata = 1'b0, done_dma = 1'b0;
    logic       pio_ready = 1'b0, pio_want_irq = 1'b0;
    logic       diag_start = 1'b0, diag_done = 1'b0, diag_want_irq = 1'b0;
    logic       intrq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Requirement-level model state.
    bit m_p = 0, m_e = 1, m_d = 0, m_i = 0;

    always #2 clk = ~clk;

    ata_irq_pending u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .done_nodata(done_nodata), .done_dma(done_dma),
        .pio_ready(pio_ready), .pio_want_irq(pio_want_irq),
        .diag_start(diag_start), .diag_done(diag_done), .diag_want_irq(diag_want_irq),
        .intrq(intrq)
    );

    // Operation codes used by the sweep.
    localparam int OP_RD_STATUS = 0,  OP_RD_ALT = 1,  OP_WR_CMD = 2,   OP_MASK = 3;
    localparam int OP_UNMASK = 4,     OP_SEL1 = 5,    OP_SEL0 = 6,     OP_NODATA = 7;
    localparam int OP_DMA = 8,        OP_PIO_W = 9,   OP_PIO_N = 10,   OP_DIAG_S = 11;
    localparam int OP_DIAG_W = 12,    OP_DIAG_N = 13, OP_ACK_EVT = 14, OP_CMD_PIO = 15;
    localparam int OP_IDLE = 16,      NUM_OPS = 17;

    function automatic string req_of(input int op);
        case (op)
            OP_RD_STATUS:           return "R2";
            OP_RD_ALT:              return "R3";
            OP_WR_CMD:              return "R4";
            OP_MASK:                return "R5";
            OP_UNMASK:              return "R6";
            OP_SEL1:                return "R7";
            OP_SEL0:                return "R8";
            OP_NODATA, OP_DMA:      return "R9";
            OP_PIO_W, OP_PIO_N:     return "R10";
            OP_DIAG_S, OP_DIAG_W,
            OP_DIAG_N:              return "R11";
            OP_ACK_EVT, OP_CMD_PIO: return "R12";
            default:                return "R13";
        endcase
    endfunction

    // Update model from the requirement text for one operation.
    task automatic model(input int op);
        case (op)
            OP_RD_STATUS, OP_WR_CMD, OP_DIAG_S: begin m_p = 0; m_i = 0; end
            OP_MASK:   begin m_i = 0; m_e = 0; end
            OP_UNMASK: begin if (!m_e && !m_d && m_p) m_i = 1; m_e = 1; end
            OP_SEL1:   begin if (!m_d) m_i = 0; m_d = 1; end
            OP_SEL0:   begin if (m_d && m_e && m_p) m_i = 1; m_d = 0; end
            OP_NODATA, OP_DMA, OP_DIAG_W: begin m_p = 1; if (m_e) m_i = 1; end
            OP_PIO_W:  begin if (m_e) begin m_p = 1; m_i = 1; end end
            OP_ACK_EVT: begin m_p = 1; m_i = m_e; end
            OP_CMD_PIO: begin m_p = 0; m_i = 0; if (m_e) begin m_p = 1; m_i = 1; end end
            default: ;
        endcase
    endtask

    task automatic check(input bit cond, input string req, input string what,
                         input int act_v, input int exp_v);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
        end
    endtask

    // Drive one operation for one cycle, then check the line after the edge.
    task automatic apply(input int op, input string tag);
        @(negedge clk);
        case (op)
            OP_RD_STATUS: begin reg_rd = 1; reg_addr = 3'd0; end
            OP_RD_ALT:    begin reg_rd = 1; reg_addr = 3'd1; end
            OP_WR_CMD:    begin reg_wr = 1; reg_addr = 3'd4; reg_wdata = 8'hEC; end
            OP_MASK:      begin reg_wr = 1; reg_addr = 3'd3; reg_wdata = 8'h02; end
            OP_UNMASK:    begin reg_wr = 1; reg_addr = 3'd3; reg_wdata = 8'hFD; end
            OP_SEL1:      begin reg_wr = 1; reg_addr = 3'd2; reg_wdata = 8'hF0; end
            OP_SEL0:      begin reg_wr = 1; reg_addr = 3'd2; reg_wdata = 8'hEF; end
            OP_NODATA:    done_nodata = 1;
            OP_DMA:       done_dma = 1;
            OP_PIO_W:     begin pio_ready = 1; pio_want_irq = 1; end
            OP_PIO_N:     pio_ready = 1;
            OP_DIAG_S:    diag_start = 1;
            OP_DIAG_W:    begin diag_done = 1; diag_want_irq = 1; end
            OP_DIAG_N:    diag_done = 1;
            OP_ACK_EVT:   begin reg_rd = 1; reg_addr = 3'd0; done_nodata = 1; end
            OP_CMD_PIO:   begin reg_wr = 1; reg_addr = 3'd4; pio_ready = 1; pio_want_irq = 1; end
            default: ;
        endcase
        model(op);
        @(negedge clk);
        reg_rd = 0; reg_wr = 0; reg_addr = 3'd0; reg_wdata = 8'h00;
        done_nodata = 0; done_dma = 0; pio_ready = 0; pio_want_irq = 0;
        diag_start = 0; diag_done = 0; diag_want_irq = 0;
        check(intrq == m_i, tag, "intrq", int'(intrq), int'(m_i));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state - line low, then enabled with nothing pending.
        check(intrq == 1'b0, "R1", "intrq after reset", int'(intrq), 0);
        apply(OP_IDLE, "R1");
        apply(OP_UNMASK, "R1");   // no restore: nothing pending, already enabled
        apply(OP_NODATA, "R1");   // enabled after reset: line rises
        apply(OP_RD_STATUS, "R2");

        for (int s = 0; s < 8; s++) begin
            for (int op = 0; op < NUM_OPS; op++) begin
                bit want_e, want_d, want_p;
                want_e = s[0]; want_d = s[1]; want_p = s[2];
                // Set up the start state.
                apply(OP_WR_CMD, "R4");
                apply(OP_SEL0, "R8");
                apply(OP_UNMASK, "R6");
                if (want_p) apply(OP_NODATA, "R9");
                if (!want_e) apply(OP_MASK, "R5");
                if (want_d) apply(OP_SEL1, "R7");
                // Operation under test.
                apply(op, req_of(op));
                // Probe the pending flag through the ports.
                apply(OP_SEL0, "R8");
                apply(OP_MASK, "R5");
                apply(OP_UNMASK, req_of(op));
                apply(OP_IDLE, "R13");
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule